// File: doc/BRIEF.md
# Compare-and-Skip Execution Unit

This unit carries out two single-word conditional-skip instructions for an 8-bit accumulator-style core. Each accepted instruction word names an 8-bit file-register offset and a one-bit addressing choice. From these the unit builds a 12-bit data address, reads that byte from the register file, and compares it as an unsigned number with the working register W. The comparison is a subtraction of W from the file byte. No status flags are written. The unit then tells the fetch stage whether the instruction it has already fetched must be turned into no-operation cycles, and how many such cycles are needed.

Instruction words arrive on a valid/ready stream. A word is taken on a rising edge where `instr_valid` and `instr_ready` are both high. While an instruction executes, `instr_ready` stays low. The producer must then hold its word and may keep `instr_valid` high. Nothing on the stream is dropped or duplicated. The unit captures W, the bank register and the prefetch two-word flag in the same edge that takes the word. Each instruction runs through four internal phases: decode, read, process, idle. The skip result is registered at the end of the idle phase, so the fetch stage can act on it in the following cycle.

Top module: `cskip_unit`

## Requirements
- R1: `instr_ready` is high exactly when no instruction is in progress. A word is taken only on an edge where `instr_valid` and `instr_ready` are both high. `wreg`, `bank_sel` and `next_two_word` are sampled on that same edge, and later changes to them have no effect on that instruction.
- R2: Bits [15:9] select the operation: `0110010` is compare-greater and `0110000` is compare-less. Bit 8 is the addressing choice and bits [7:0] are the file offset. Any other value of bits [15:9] gives no skip and a cycle count of 1.
- R3: When bit 8 is 0, `bank_sel` is ignored. An offset below 0x60 addresses 0x000 plus the offset. An offset of 0x60 or above addresses 0xF00 plus the offset.
- R4: When bit 8 is 1, the address is `{bank_sel[3:0], offset}`.
- R5: `dmem_rd_en` is high for exactly one cycle, the second cycle after the accepting edge, with the address on `dmem_addr`. The read port returns the byte one cycle later.
- R6: Compare-greater requests a skip only when the file byte is strictly greater than W, as unsigned numbers. Equal values do not skip.
- R7: Compare-less requests a skip only when the file byte is strictly less than W, as unsigned numbers. Equal values do not skip.
- R8: `squash_cycles` is 0 when there is no skip, 1 when there is a skip and `next_two_word` was low, and 2 when there is a skip and `next_two_word` was high. `cycle_count` equals `squash_cycles` + 1.
- R9: `result_valid` is high for one cycle, four cycles after the accepting edge. `skip_req`, `squash_cycles` and `cycle_count` are zero whenever `result_valid` is low. `instr_ready` is high again in the same cycle as `result_valid`.
- R10: During and directly after reset, `instr_ready` is high and `result_valid` and `dmem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle; accepts a word |
| instr_word | input | 16 | Instruction word |
| wreg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank register (upper address bits) |
| next_two_word | input | 1 | Prefetched next instruction is two words long |
| dmem_rd_en | output | 1 | Register file read strobe |
| dmem_addr | output | 12 | Register file read address |
| dmem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| result_valid | output | 1 | Skip decision valid this cycle |
| skip_req | output | 1 | Squash the already-fetched instruction |
| squash_cycles | output | 2 | Number of no-operation cycles to insert |
| cycle_count | output | 2 | Total cycles taken by the instruction |

## Verification
On every cycle, the assertions check the timing and the handshake. Ready must drop after each accept. The single read strobe must fall in the second cycle after the accept, and the result pulse must come three cycles after the strobe. The outputs must read zero outside the pulse, and the squash count must agree with the skip flag and the cycle total. Only the bench's scenarios can show that the right byte was fetched and that the unsigned decision is correct. These scenarios sweep every file value against W values at both ends of the range and at the midpoint, for both operations and a non-matching opcode. They also cover the common-window split at 0x5F/0x60, equal operands, both squash lengths, and inputs that change or a valid that stays high while an instruction is executing.

// File: rtl/cskip_pkg.sv
package cskip_pkg;

  localparam int INSTR_W = 16;
  localparam int FILE_W  = 8;
  localparam int OPC_W   = 7;

  localparam logic [OPC_W-1:0] OPC_CMP_GT = 7'b0110010;
  localparam logic [OPC_W-1:0] OPC_CMP_LT = 7'b0110000;

  typedef enum logic [1:0] {
    CMP_NONE = 2'd0,
    CMP_GT   = 2'd1,
    CMP_LT   = 2'd2
  } cmp_kind_e;

  typedef enum logic [1:0] {
    PH_DECODE  = 2'd0,
    PH_READ    = 2'd1,
    PH_PROCESS = 2'd2,
    PH_IDLE    = 2'd3
  } phase_e;

  typedef struct packed {
    cmp_kind_e         kind;
    logic              use_bank;
    logic [FILE_W-1:0] file;
  } dec_t;

endpackage

// File: rtl/cskip_decode.sv
module cskip_decode
  import cskip_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output dec_t               dec
);

  logic [OPC_W-1:0] opc;
  assign opc = word[INSTR_W-1 -: OPC_W];

  always_comb begin
    dec.use_bank = word[FILE_W];
    dec.file     = word[FILE_W-1:0];
    if (opc == OPC_CMP_GT)      dec.kind = CMP_GT;
    else if (opc == OPC_CMP_LT) dec.kind = CMP_LT;
    else                        dec.kind = CMP_NONE;
  end

endmodule

// File: rtl/cskip_addr_gen.sv
module cskip_addr_gen #(
  parameter int FILE_W = 8,
  parameter int BANK_W = 4,
  parameter logic [FILE_W-1:0] SPLIT = 8'h60,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input  logic [FILE_W-1:0] file,
  input  logic              use_bank,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr
);

  logic [BANK_W-1:0] upper;

  always_comb begin
    if (use_bank)          upper = bank;
    else if (file < SPLIT) upper = '0;
    else                   upper = '1;
  end

  assign addr = {upper, file};

endmodule

// File: rtl/cskip_compare.sv
module cskip_compare
  import cskip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  cmp_kind_e         kind,
  input  logic [DATA_W-1:0] fval,
  input  logic [DATA_W-1:0] wval,
  input  logic              two_word,
  output logic              hit,
  output logic [1:0]        squash
);

  logic [DATA_W:0] diff;
  logic            borrow;
  logic            nonzero;

  assign diff    = {1'b0, fval} - {1'b0, wval};
  assign borrow  = diff[DATA_W];
  assign nonzero = |diff[DATA_W-1:0];

  always_comb begin
    case (kind)
      CMP_GT:  hit = !borrow && nonzero;
      CMP_LT:  hit = borrow;
      default: hit = 1'b0;
    endcase
    squash = hit ? (two_word ? 2'd2 : 2'd1) : 2'd0;
  end

endmodule

// File: rtl/cskip_unit.sv
module cskip_unit
  import cskip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter logic [FILE_W-1:0] SPLIT = 8'h60,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0]  wreg,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               next_two_word,
  output logic               dmem_rd_en,
  output logic [ADDR_W-1:0]  dmem_addr,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               result_valid,
  output logic               skip_req,
  output logic [1:0]         squash_cycles,
  output logic [1:0]         cycle_count
);

  logic               busy;
  phase_e             phase;
  logic [INSTR_W-1:0] word_q;
  logic [DATA_W-1:0]  w_q;
  logic [BANK_W-1:0]  bank_q;
  logic               tw_q;
  dec_t               dec_c;
  dec_t               dec_q;
  logic [ADDR_W-1:0]  addr_c;
  logic [ADDR_W-1:0]  addr_q;
  logic               hit_c;
  logic [1:0]         squash_c;
  logic               hit_q;
  logic [1:0]         squash_q;
  logic               accept;
  logic               finish;

  assign instr_ready = !busy;
  assign accept      = instr_valid && !busy;
  assign finish      = busy && (phase == PH_IDLE);
  assign dmem_rd_en  = busy && (phase == PH_READ);
  assign dmem_addr   = addr_q;

  cskip_decode u_decode (
    .word (word_q),
    .dec  (dec_c)
  );

  cskip_addr_gen #(
    .FILE_W (FILE_W),
    .BANK_W (BANK_W),
    .SPLIT  (SPLIT)
  ) u_addr (
    .file     (dec_c.file),
    .use_bank (dec_c.use_bank),
    .bank     (bank_q),
    .addr     (addr_c)
  );

  cskip_compare #(
    .DATA_W (DATA_W)
  ) u_cmp (
    .kind     (dec_q.kind),
    .fval     (dmem_rdata),
    .wval     (w_q),
    .two_word (tw_q),
    .hit      (hit_c),
    .squash   (squash_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= PH_DECODE;
      word_q   <= '0;
      w_q      <= '0;
      bank_q   <= '0;
      tw_q     <= 1'b0;
      dec_q    <= '0;
      addr_q   <= '0;
      hit_q    <= 1'b0;
      squash_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      phase  <= PH_DECODE;
      word_q <= instr_word;
      w_q    <= wreg;
      bank_q <= bank_sel;
      tw_q   <= next_two_word;
    end else if (busy) begin
      case (phase)
        PH_DECODE: begin
          dec_q  <= dec_c;
          addr_q <= addr_c;
          phase  <= PH_READ;
        end
        PH_READ: begin
          phase <= PH_PROCESS;
        end
        PH_PROCESS: begin
          hit_q    <= hit_c;
          squash_q <= squash_c;
          phase    <= PH_IDLE;
        end
        default: begin
          busy  <= 1'b0;
          phase <= PH_DECODE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid  <= 1'b0;
      skip_req      <= 1'b0;
      squash_cycles <= '0;
      cycle_count   <= '0;
    end else begin
      result_valid  <= finish;
      skip_req      <= finish && hit_q;
      squash_cycles <= finish ? squash_q : 2'd0;
      cycle_count   <= finish ? (squash_q + 2'd1) : 2'd0;
    end
  end

endmodule

// File: rtl/cskip_unit_chk.sv
module cskip_unit_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic              dmem_rd_en,
  input logic [ADDR_W-1:0] dmem_addr,
  input logic              result_valid,
  input logic              skip_req,
  input logic [1:0]        squash_cycles,
  input logic [1:0]        cycle_count
);

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready) |=> !instr_ready);

  p_read_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready) |=> ##1 dmem_rd_en);

  p_read_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd_en |=> !dmem_rd_en);

  p_read_addr_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd_en |-> !$isunknown(dmem_addr));

  p_no_ready_in_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd_en |-> !instr_ready);

  p_result_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd_en |-> ##3 result_valid);

  p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_ready_on_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> instr_ready);

  p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> (!skip_req && squash_cycles == 2'd0 && cycle_count == 2'd0));

  p_squash_vs_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ((squash_cycles != 2'd0) == skip_req && squash_cycles != 2'd3));

  p_cycle_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cycle_count == squash_cycles + 2'd1));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_state_r10: assert (instr_ready && !result_valid && !dmem_rd_en);
    end
  end

endmodule

bind cskip_unit cskip_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .instr_ready   (instr_ready),
  .dmem_rd_en    (dmem_rd_en),
  .dmem_addr     (dmem_addr),
  .result_valid  (result_valid),
  .skip_req      (skip_req),
  .squash_cycles (squash_cycles),
  .cycle_count   (cycle_count)
);

// File: tb/cskip_unit_tb_top.sv
module cskip_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = '0;
  logic [7:0]  wreg = '0;
  logic [3:0]  bank_sel = '0;
  logic        next_two_word = 1'b0;
  logic        dmem_rd_en;
  logic [11:0] dmem_addr;
  logic [7:0]  dmem_rdata = '0;
  logic        result_valid;
  logic        skip_req;
  logic [1:0]  squash_cycles;
  logic [1:0]  cycle_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:4095];

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (dmem_rd_en) dmem_rdata <= mem[dmem_addr];
  end

  cskip_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .instr_word    (instr_word),
    .wreg          (wreg),
    .bank_sel      (bank_sel),
    .next_two_word (next_two_word),
    .dmem_rd_en    (dmem_rd_en),
    .dmem_addr     (dmem_addr),
    .dmem_rdata    (dmem_rdata),
    .result_valid  (result_valid),
    .skip_req      (skip_req),
    .squash_cycles (squash_cycles),
    .cycle_count   (cycle_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One instruction; hold keeps valid high with a junk word while busy.
  task automatic run_one(input logic [15:0] word, input logic [7:0] w,
                         input logic [3:0] b, input bit tw, input logic [7:0] fv,
                         input bit hold);
    logic [6:0]  opc;
    logic [7:0]  f;
    logic [11:0] eaddr;
    bit          eskip;
    int          esq;
    string       rtag;
    string       atag;
    opc = word[15:9];
    f   = word[7:0];
    if (word[8]) begin
      eaddr = {b, f};
      atag  = "R4";
    end else begin
      eaddr = (f < 8'h60) ? {4'h0, f} : {4'hF, f};
      atag  = "R3";
    end
    if (opc == 7'b0110010) begin
      eskip = (fv > w);
      rtag  = "R6";
    end else if (opc == 7'b0110000) begin
      eskip = (fv < w);
      rtag  = "R7";
    end else begin
      eskip = 1'b0;
      rtag  = "R2";
    end
    esq = eskip ? (tw ? 2 : 1) : 0;
    mem[eaddr] = fv;
    mem[eaddr ^ 12'h001] = ~fv;

    @(negedge clk);
    instr_valid   = 1'b1;
    instr_word    = word;
    wreg          = w;
    bank_sel      = b;
    next_two_word = tw;
    chk(instr_ready == 1'b1, "R1 ready idle", int'(instr_ready), 1);

    @(negedge clk);
    instr_valid   = hold;
    instr_word    = ~word;
    wreg          = ~w;
    bank_sel      = ~b;
    next_two_word = ~tw;
    chk(instr_ready == 1'b0, "R1 ready busy", int'(instr_ready), 0);
    chk(dmem_rd_en == 1'b0, "R5 early read", int'(dmem_rd_en), 0);

    @(negedge clk);
    chk(dmem_rd_en == 1'b1, "R5 read strobe", int'(dmem_rd_en), 1);
    chk(dmem_addr == eaddr, atag, int'(dmem_addr), int'(eaddr));

    @(negedge clk);
    chk(dmem_rd_en == 1'b0, "R5 single read", int'(dmem_rd_en), 0);
    chk(result_valid == 1'b0, "R9 early result", int'(result_valid), 0);

    @(negedge clk);
    chk(result_valid == 1'b0, "R9 early result", int'(result_valid), 0);
    chk(instr_ready == 1'b0, "R1 ready busy", int'(instr_ready), 0);

    @(negedge clk);
    instr_valid = 1'b0;
    chk(result_valid == 1'b1, "R9 result pulse", int'(result_valid), 1);
    chk(skip_req == eskip, rtag, int'(skip_req), int'(eskip));
    chk(int'(squash_cycles) == esq, "R8 squash", int'(squash_cycles), esq);
    chk(int'(cycle_count) == esq + 1, "R8 cycles", int'(cycle_count), esq + 1);
    chk(instr_ready == 1'b1, "R9 ready back", int'(instr_ready), 1);

    @(negedge clk);
    chk(result_valid == 1'b0 && skip_req == 1'b0 && squash_cycles == 2'd0,
        "R9 quiet", int'({result_valid, skip_req, squash_cycles}), 0);
  endtask

  initial begin
    logic [7:0] wl [6];
    wl[0] = 8'h00; wl[1] = 8'h01; wl[2] = 8'h7F;
    wl[3] = 8'h80; wl[4] = 8'hFE; wl[5] = 8'hFF;
    for (int i = 0; i < 4096; i++) mem[i] = i[7:0] ^ 8'h5A;

    repeat (3) @(negedge clk);
    chk(instr_ready && !result_valid && !dmem_rd_en, "R10 in reset",
        int'({instr_ready, result_valid, dmem_rd_en}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(instr_ready && !result_valid && !dmem_rd_en, "R10 after reset",
        int'({instr_ready, result_valid, dmem_rd_en}), 4);

    // R3 split boundary, bank register ignored
    run_one({7'b0110010, 1'b0, 8'h5F}, 8'h10, 4'h7, 1'b0, 8'h20, 1'b0);
    run_one({7'b0110010, 1'b0, 8'h60}, 8'h10, 4'h7, 1'b1, 8'h20, 1'b0);
    run_one({7'b0110000, 1'b0, 8'h00}, 8'h10, 4'h3, 1'b0, 8'h00, 1'b1);
    run_one({7'b0110000, 1'b0, 8'hFF}, 8'h10, 4'h3, 1'b1, 8'h0F, 1'b0);
    // R4 bank addressing extremes
    run_one({7'b0110010, 1'b1, 8'hFF}, 8'hFE, 4'hF, 1'b1, 8'hFF, 1'b0);
    run_one({7'b0110000, 1'b1, 8'h00}, 8'h01, 4'h0, 1'b0, 8'h00, 1'b1);
    // R6 R7 equal operands at both ends
    run_one({7'b0110010, 1'b1, 8'h12}, 8'h00, 4'h2, 1'b0, 8'h00, 1'b0);
    run_one({7'b0110000, 1'b1, 8'h12}, 8'hFF, 4'h2, 1'b0, 8'hFF, 1'b0);

    // Sweep: every file value against a set of W values, three opcodes
    for (int k = 0; k < 3; k++) begin
      for (int wi = 0; wi < 6; wi++) begin
        for (int fv = 0; fv < 256; fv += (k == 2) ? 17 : 1) begin
          logic [6:0]  opc;
          logic [15:0] word;
          logic [7:0]  fb;
          logic [7:0]  fa;
          fb  = fv[7:0];
          opc = (k == 0) ? 7'b0110010 : (k == 1) ? 7'b0110000 : 7'b0110101;
          fa  = fb * 8'd7 + 8'(wi);
          word = {opc, fb[0] ^ wi[0], fa};
          run_one(word, wl[wi], fb[7:4] ^ wi[3:0], fb[1], fb, fb[2]);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule